// File: doc/BRIEF.md
# Six-Level Stacked-Carrier PWM Gate Generator

This block drives the gates of a three-phase inverter whose legs each have five clamped DC-bus segments, so each phase output can sit at one of six levels, 0 to 5. For every phase, a digital sine reference is compared against five triangular carriers. The carriers share one shape, and each is lifted by a fixed offset into its own band of the total range. The number of carriers that the reference lies strictly above is the phase level. That level is decoded into the ten gate bits of the leg, and the gate bits are registered through per-switch turn-on delay counters.

One phase accumulator addresses an internal sine table for all three phases, with the second and third phases one third and two thirds of a cycle ahead. A modulation word scales the sine around the mid-point of the range. A phase-step word sets the reference frequency, and a divider word sets how many clocks each carrier step lasts. A dead-time word sets how many clock cycles a switch must stay commanded on before it actually turns on.

The block is used by holding `enable` high once the control words are set. Dropping `enable` turns every gate off on the next clock.

Top module: `mlpwm_top`

## Requirements
- R1: The gate bit layout is the same for each phase. Bits [4:0] are upper switches 1..5 (bit j-1 is upper switch j), and bits [9:5] are lower switches 1..5 (bit 4+j is lower switch j). At level k, upper switch j is on exactly when j >= 6-k, and lower switch j is on exactly when j <= 5-k. Level 5 is therefore 10'b00000_11111 and level 0 is 10'b11111_00000.
- R2: The level of a phase is the number of carriers i (i = 0..4) for which the reference is strictly greater than i*SPAN + c. Here c is the shared triangle value.
- R3: The shared triangle c runs 0,1,...,SPAN,SPAN-1,...,1,0,... and takes one step every car_div+1 clocks, so its period is 2*SPAN*(car_div+1) clocks.
- R4: The reference is 5*SPAN/2 + s*m*(5*SPAN/2)/(SMAX*MMAX), where s is the signed sine sample and m is mod_idx. With m = 0 every phase alternates between levels 2 and 3, spending close to half the time at each.
- R5: The phases read the table at accumulator offsets 0, 2^PH_W/3 and 2*2^PH_W/3. With ref_fw = 0 and full modulation, phase a stays in levels {2,3}, phase b in {4,5} and phase c in {0,1}. Phase c spends about 43% of its time at level 1.
- R6: At full modulation with a running reference, every phase visits both level 0 and level 5.
- R7: While rst_n is low, and from the first clock after enable is sampled low, all 30 gate bits are 0.
- R8: A gate bit turns on only after its command has stayed high for dead_cyc clocks. The upper and lower switch of the same index are never on together, and the off gap between them is at least dead_cyc clocks.
- R9: With dead_cyc = 0, each gate vector is exactly the R1 pattern of some level, so exactly five switches per leg are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run; low clears the generators and turns all gates off |
| mod_idx | input | MOD_W | Modulation word m, 0 to 2^MOD_W-1 |
| ref_fw | input | PH_W | Reference phase step per clock |
| car_div | input | DIV_W | Clocks per carrier step, minus one |
| dead_cyc | input | DT_W | Turn-on delay in clocks |
| gates_a | output | 10 | Phase a gate bits (R1 layout) |
| gates_b | output | 10 | Phase b gate bits (R1 layout) |
| gates_c | output | 10 | Phase c gate bits (R1 layout) |

## Verification
The assertions check several properties on every cycle:
- the triangle moves by at most one step;
- the references stay inside 0..5*SPAN and sit exactly at mid-scale after a zero modulation word;
- complementary switches are never on together;
- a gate rises only on a high command;
- an idle enable clears all gates.

Other properties depend on how the waveforms relate over time, so only the bench scenarios can show them:
- level occupancy fractions at fixed references;
- the exact triangle period for several divider words;
- the full level sweep;
- the minimum dead gap measured at the ports.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  localparam int NCAR  = 5;
  localparam int NGATE = 2 * NCAR;
  localparam int LVL_W = $clog2(NCAR + 1);

  // R1: level k -> upper j on when j >= NCAR+1-k, lower j on when j <= NCAR-k
  function automatic logic [NGATE-1:0] level_gates(input logic [LVL_W-1:0] lvl);
    logic [NGATE-1:0] g;
    g = '0;
    for (int j = 1; j <= NCAR; j++) begin
      g[j-1]      = (j >= NCAR + 1 - int'(lvl));
      g[NCAR+j-1] = (j <= NCAR - int'(lvl));
    end
    return g;
  endfunction

  // Rational sine approximation over one full period of len entries
  function automatic int sine_val(input int idx, input int len, input int smax);
    int half, x, p, v;
    half = len / 2;
    x = (idx < half) ? idx : idx - half;
    p = x * (half - x);
    v = (smax * 16 * p) / (5 * half * half - 4 * p);
    return (idx < half) ? v : -v;
  endfunction

  // R4: reference = mid + s*m*mid/(smax*mmax)
  function automatic int ref_scale(input int s, input int m, input int mid,
                                   input int smax, input int mmax);
    int mag;
    mag = ((s < 0) ? -s : s) * m * mid / (smax * mmax);
    return (s < 0) ? mid - mag : mid + mag;
  endfunction

  // R2: count of stacked carriers below the reference
  function automatic logic [LVL_W-1:0] count_above(input logic [NCAR-1:0] above);
    logic [LVL_W-1:0] n;
    n = '0;
    for (int i = 0; i < NCAR; i++) n = n + LVL_W'(above[i]);
    return n;
  endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier
  import mlpwm_pkg::*;
#(
  parameter int SPAN  = 64,
  parameter int DIV_W = 16,
  parameter int CW    = $clog2(SPAN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] car_div,
  output logic [CW-1:0]    tri_val
);

  logic [DIV_W-1:0] pre_cnt;
  logic             going_up;
  logic             step_evt;

  assign step_evt = run && (pre_cnt == car_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tri_val  <= '0;
      going_up <= 1'b1;
    end else if (!run) begin
      pre_cnt  <= '0;
      tri_val  <= '0;
      going_up <= 1'b1;
    end else if (step_evt) begin
      pre_cnt <= '0;
      if (going_up) begin
        tri_val <= tri_val + 1'b1;
        if (tri_val == CW'(SPAN - 1)) going_up <= 1'b0;
      end else begin
        tri_val <= tri_val - 1'b1;
        if (tri_val == CW'(1)) going_up <= 1'b1;
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // R3: the triangle stays in range and moves by at most one per clock
  a_r3_carrier_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ((tri_val <= CW'(SPAN)) &&
      ((tri_val == $past(tri_val)) || (tri_val == $past(tri_val) + 1'b1) ||
       ($past(tri_val) == tri_val + 1'b1))));

endmodule

// File: rtl/mlpwm_refgen.sv
module mlpwm_refgen
  import mlpwm_pkg::*;
#(
  parameter int PH_W   = 16,
  parameter int LUT_AW = 6,
  parameter int SW     = 8,
  parameter int MOD_W  = 8,
  parameter int SPAN   = 64,
  parameter int REF_W  = $clog2(NCAR * SPAN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [MOD_W-1:0]      mod_idx,
  input  logic [PH_W-1:0]       ref_fw,
  output logic [2:0][REF_W-1:0] ref_q
);

  localparam int LUT_N = 1 << LUT_AW;
  localparam int SMAX  = (1 << (SW - 1)) - 1;
  localparam int MMAX  = (1 << MOD_W) - 1;
  localparam int MID   = (NCAR * SPAN) / 2;
  localparam int TOP   = NCAR * SPAN;
  localparam logic [PH_W-1:0] OFS1 = PH_W'((1 << PH_W) / 3);
  localparam logic [PH_W-1:0] OFS2 = PH_W'((2 * (1 << PH_W)) / 3);

  logic signed [SW-1:0] sine_rom [LUT_N];
  logic [PH_W-1:0]      acc;
  logic [2:0][PH_W-1:0] ph;

  for (genvar k = 0; k < LUT_N; k++) begin : g_rom
    assign sine_rom[k] = SW'(sine_val(k, LUT_N, SMAX));
  end

  assign ph[0] = acc;
  assign ph[1] = acc + OFS1;
  assign ph[2] = acc + OFS2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (!run) acc <= '0;
    else          acc <= acc + ref_fw;
  end

  // R5: three phases read one table at one-third cycle offsets
  for (genvar p = 0; p < 3; p++) begin : g_ph
    logic signed [SW-1:0] samp;
    assign samp = sine_rom[ph[p][PH_W-1 -: LUT_AW]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_q[p] <= REF_W'(MID);
      else        ref_q[p] <= REF_W'(ref_scale(int'(samp), int'(mod_idx), MID, SMAX, MMAX));
    end

    // R4: the reference never leaves the stacked range
    a_r4_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q[p] <= REF_W'(TOP));

    // R4: a zero modulation word pins the reference at mid-scale
    a_r4_zero_mid: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mod_idx) == '0) |-> (ref_q[p] == REF_W'(MID)));
  end

endmodule

// File: rtl/mlpwm_leg.sv
module mlpwm_leg
  import mlpwm_pkg::*;
#(
  parameter int SPAN  = 64,
  parameter int REF_W = $clog2(NCAR * SPAN + 1),
  parameter int CW    = $clog2(SPAN + 1),
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REF_W-1:0] ref_v,
  input  logic [CW-1:0]    tri_val,
  input  logic [DT_W-1:0]  dead_cyc,
  output logic [NGATE-1:0] gates
);

  logic [NCAR-1:0]  above;
  logic [LVL_W-1:0] level;
  logic [NGATE-1:0] cmd;

  // R2: carrier i sits in band i*SPAN .. (i+1)*SPAN
  for (genvar i = 0; i < NCAR; i++) begin : g_cmp
    logic [REF_W:0] car_lvl;
    assign car_lvl  = (REF_W+1)'(i * SPAN) + (REF_W+1)'(tri_val);
    assign above[i] = ({1'b0, ref_v} > car_lvl);
  end

  assign level = count_above(above);
  assign cmd   = run ? level_gates(level) : '0;

  // R8: per-switch turn-on delay
  for (genvar j = 0; j < NGATE; j++) begin : g_dt
    logic [DT_W-1:0] hold;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold     <= '0;
        gates[j] <= 1'b0;
      end else if (!cmd[j]) begin
        hold     <= dead_cyc;
        gates[j] <= 1'b0;
      end else if (hold != '0) begin
        hold     <= hold - 1'b1;
        gates[j] <= 1'b0;
      end else begin
        gates[j] <= 1'b1;
      end
    end

    // R8: a gate rises only while its command is high
    a_r8_rise_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gates[j]) |-> $past(cmd[j]));
  end

  for (genvar j = 0; j < NCAR; j++) begin : g_pair
    // R8: complementary switches never conduct together
    a_r8_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(gates[j] && gates[NCAR+j]));
  end

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int PH_W   = 16,
  parameter int LUT_AW = 6,
  parameter int SW     = 8,
  parameter int MOD_W  = 8,
  parameter int SPAN   = 64,
  parameter int DIV_W  = 16,
  parameter int DT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [MOD_W-1:0] mod_idx,
  input  logic [PH_W-1:0]  ref_fw,
  input  logic [DIV_W-1:0] car_div,
  input  logic [DT_W-1:0]  dead_cyc,
  output logic [9:0]       gates_a,
  output logic [9:0]       gates_b,
  output logic [9:0]       gates_c
);

  localparam int REF_W = $clog2(NCAR * SPAN + 1);
  localparam int CW    = $clog2(SPAN + 1);

  logic [CW-1:0]           tri_val;
  logic [2:0][REF_W-1:0]   ref_q;
  logic [2:0][NGATE-1:0]   leg_g;

  mlpwm_carrier #(.SPAN(SPAN), .DIV_W(DIV_W), .CW(CW)) u_carrier (
    .clk(clk), .rst_n(rst_n), .run(enable), .car_div(car_div), .tri_val(tri_val)
  );

  mlpwm_refgen #(.PH_W(PH_W), .LUT_AW(LUT_AW), .SW(SW), .MOD_W(MOD_W),
                 .SPAN(SPAN), .REF_W(REF_W)) u_refgen (
    .clk(clk), .rst_n(rst_n), .run(enable), .mod_idx(mod_idx),
    .ref_fw(ref_fw), .ref_q(ref_q)
  );

  for (genvar p = 0; p < 3; p++) begin : g_leg
    mlpwm_leg #(.SPAN(SPAN), .REF_W(REF_W), .CW(CW), .DT_W(DT_W)) u_leg (
      .clk(clk), .rst_n(rst_n), .run(enable), .ref_v(ref_q[p]),
      .tri_val(tri_val), .dead_cyc(dead_cyc), .gates(leg_g[p])
    );
  end

  assign gates_a = leg_g[0];
  assign gates_b = leg_g[1];
  assign gates_c = leg_g[2];

  // R7: a low enable clears every gate on the next clock
  a_r7_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ({gates_a, gates_b, gates_c} == '0));

endmodule

// File: tb/mlpwm_top_bench.sv
module mlpwm_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] mod_idx = '0;
  logic [15:0] ref_fw = '0;
  logic [15:0] car_div = '0;
  logic [3:0] dead_cyc = '0;
  logic [9:0] gates_a, gates_b, gates_c;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int zrun [3][10];
  int dead_viol, pair_viol, rises;

  always #5 clk = ~clk;

  mlpwm_top u_mlpwm_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mod_idx(mod_idx),
    .ref_fw(ref_fw), .car_div(car_div), .dead_cyc(dead_cyc),
    .gates_a(gates_a), .gates_b(gates_b), .gates_c(gates_c)
  );

  // Bench view of R1: upper mask from the top, lower mask from the bottom
  function automatic logic [9:0] pat(input int k);
    logic [4:0] up, lo;
    up = 5'((5'b11111 << (5 - k)) & 5'b11111);
    lo = 5'((1 << (5 - k)) - 1);
    return {lo, up};
  endfunction

  function automatic int lvl_of(input logic [9:0] v);
    for (int k = 0; k <= 5; k++) if (v == pat(k)) return k;
    return -1;
  endfunction

  function automatic logic [9:0] gsel(input int p);
    return (p == 0) ? gates_a : (p == 1) ? gates_b : gates_c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    cyc++;
  endtask

  // Steady run: count level occupancy per phase and bad vectors
  task automatic sweep(input int n, output int cnt [3][6], output int bad);
    bad = 0;
    for (int p = 0; p < 3; p++) for (int k = 0; k < 6; k++) cnt[p][k] = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      for (int p = 0; p < 3; p++) begin
        int l;
        l = lvl_of(gsel(p));
        if (l < 0) bad++;
        else cnt[p][l]++;
      end
    end
  endtask

  task automatic restart;
    enable = 1'b0;
    tick(); tick();
    enable = 1'b1;
    for (int i = 0; i < 4; i++) tick();
  endtask

  // R3: measure the 2->3 transition spacing on phase a
  task automatic period_check(input int div);
    int last, prev, per1, per2, pl, l;
    car_div = 16'(div);
    restart();
    last = -1; per1 = -1; per2 = -2; pl = lvl_of(gates_a);
    for (int i = 0; i < 2 * 128 * (div + 1) * 3 + 10; i++) begin
      tick();
      l = lvl_of(gates_a);
      if (pl == 2 && l == 3) begin
        if (last >= 0) begin
          prev = per1;
          per1 = cyc - last;
          per2 = prev;
        end
        last = cyc;
      end
      pl = l;
    end
    check(per1 == 128 * (div + 1), "R3 carrier period", per1, 128 * (div + 1));
    check(per2 == per1, "R3 period repeat", per2, per1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt [3][6];
    int bad;
    int mn, mx;

    // R7: gates off while in reset
    tick(); tick();
    check({gates_a, gates_b, gates_c} == 30'd0, "R7 reset off", int'({gates_a, gates_b, gates_c}), 0);
    rst_n = 1'b1;
    tick();
    check({gates_a, gates_b, gates_c} == 30'd0, "R7 idle enable off", int'(gates_a), 0);

    // R4/R9: zero modulation -> levels 2 and 3 only, about half each
    enable = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    sweep(1280, cnt, bad);
    check(bad == 0, "R9 five-on pattern m=0", bad, 0);
    mx = 0;
    for (int p = 0; p < 3; p++) mx += 1280 - cnt[p][2] - cnt[p][3];
    check(mx == 0, "R4 only levels 2/3 at m=0", mx, 0);
    check(cnt[0][3] >= 580 && cnt[0][3] <= 680, "R4 R2 level-3 share", cnt[0][3], 630);

    // R3: triangle period for several divider words
    period_check(0);
    period_check(1);
    period_check(3);
    car_div = '0;

    // R5/R2: frozen reference at full modulation
    mod_idx = 8'hFF;
    restart();
    sweep(1280, cnt, bad);
    check(bad == 0, "R1 pattern full m", bad, 0);
    check(cnt[0][2] + cnt[0][3] == 1280, "R5 phase a in 2/3", cnt[0][2] + cnt[0][3], 1280);
    check(cnt[1][4] + cnt[1][5] == 1280, "R5 phase b in 4/5", cnt[1][4] + cnt[1][5], 1280);
    check(cnt[2][0] + cnt[2][1] == 1280, "R5 phase c in 0/1", cnt[2][0] + cnt[2][1], 1280);
    check(cnt[2][1] >= 486 && cnt[2][1] <= 614, "R5 R2 phase c level-1 share", cnt[2][1], 550);
    check(cnt[1][4] > 0 && cnt[1][5] > 0, "R2 phase b toggles", cnt[1][4], 1);

    // R6: running reference reaches both extremes on all phases
    ref_fw = 16'd64;
    restart();
    sweep(3000, cnt, bad);
    check(bad == 0, "R1 R9 pattern sweep", bad, 0);
    mn = 3000; mx = 3000;
    for (int p = 0; p < 3; p++) begin
      if (cnt[p][0] < mn) mn = cnt[p][0];
      if (cnt[p][5] < mx) mx = cnt[p][5];
    end
    check(mn > 0, "R6 level 0 reached", mn, 1);
    check(mx > 0, "R6 level 5 reached", mx, 1);

    // R8: dead time gap measured at the ports
    dead_cyc = 4'd4;
    ref_fw = '0;
    mod_idx = '0;
    restart();
    for (int p = 0; p < 3; p++) for (int b = 0; b < 10; b++) zrun[p][b] = 100;
    dead_viol = 0; pair_viol = 0; rises = 0;
    begin
      logic [9:0] prevv [3];
      for (int p = 0; p < 3; p++) prevv[p] = gsel(p);
      for (int i = 0; i < 1500; i++) begin
        tick();
        for (int p = 0; p < 3; p++) begin
          logic [9:0] v;
          v = gsel(p);
          for (int b = 0; b < 10; b++) begin
            int cb;
            cb = (b < 5) ? b + 5 : b - 5;
            if (v[b] && !prevv[p][b]) begin
              rises++;
              if (zrun[p][cb] < 4) dead_viol++;
            end
          end
          for (int b = 0; b < 5; b++) if (v[b] && v[b+5]) pair_viol++;
          for (int b = 0; b < 10; b++) zrun[p][b] = v[b] ? 0 : zrun[p][b] + 1;
          prevv[p] = v;
        end
      end
    end
    check(rises > 0, "R8 gates still switch", rises, 1);
    check(dead_viol == 0, "R8 dead gap", dead_viol, 0);
    check(pair_viol == 0, "R8 pair exclusive", pair_viol, 0);

    // R7: dropping enable clears gates after one clock
    dead_cyc = '0;
    restart();
    for (int i = 0; i < 50; i++) tick();
    check({gates_a, gates_b, gates_c} != 30'd0, "R7 running before drop", 0, 1);
    enable = 1'b0;
    tick();
    check({gates_a, gates_b, gates_c} == 30'd0, "R7 enable low off", int'(gates_a), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule